// File: doc/BRIEF.md
# Almost-Full / Almost-Empty Threshold Programmer

This block keeps the two threshold offsets of a FIFO and produces its almost-empty and almost-full flags from the current occupancy. The empty-side offset is held in register X and the full-side offset in register Y. Three loading methods exist. A method can load a fixed preset while reset is active, can take the offsets from the first two write-bus transfers after reset, or can take them from a serial bit stream that is clocked in while a serial enable is high.

The method and the preset are chosen from a serial-mode pin and a two-bit flag-select pin. Their levels are captured while the full reset is low, and the last value captured before release is kept. A partial reset clears only the flags. It leaves the offsets, the chosen method and the programming progress as they were. A done output tells the FIFO write logic when the offsets are complete, so that ordinary writes can begin.

Top module: `apf_offset_prog`

## Requirements
- R1: The method is decoded from the levels that serial_mode and flag_sel have at the last rising clock edge with rst_n low, and it is held afterwards. serial_mode=0 selects parallel loading. serial_mode=1 with flag_sel=00 selects serial loading. serial_mode=1 with any other flag_sel selects a preset.
- R2: Preset encodings set X and Y to the same value: flag_sel=01 gives 8, 10 gives 16 and 11 gives 64. prog_done is high from the first clock after reset.
- R3: In parallel mode, the first wr_en cycle after reset loads X from wr_data[OFS_W-1:0] and the second loads Y. prog_done rises with the second write, and later writes leave both offsets unchanged.
- R4: In serial mode, each clock with ser_en high shifts in one ser_din bit. The first OFS_W bits form X and the next OFS_W bits form Y, each MSB first. prog_done rises on the last bit. Clocks with ser_en low add no bit, and bits sent after done are ignored.
- R5: ae_n is low exactly when occupancy <= X. It follows occupancy one clock later.
- R6: af_n is low exactly when DEPTH - occupancy <= Y. It follows occupancy one clock later.
- R7: At every clock edge where rst_n or prst_n is low, ae_n is forced to 0 and af_n to 1.
- R8: A partial reset keeps X, Y, the method and prog_done.
- R9: The inputs of an unselected method have no effect. wr_en is ignored in serial and preset mode, and ser_en is ignored in parallel and preset mode.
- R10: In parallel and serial mode, prog_done is low after reset until the last offset is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low, synchronous sampling |
| prst_n | input | 1 | Partial reset, active low |
| serial_mode | input | 1 | Method select pin, captured in reset |
| flag_sel | input | 2 | Preset / method select pins, captured in reset |
| wr_en | input | 1 | Write strobe of the FIFO write port |
| wr_data | input | DW | Write data bus |
| ser_din | input | 1 | Serial offset data |
| ser_en | input | 1 | Serial shift enable |
| occupancy | input | CNT_W | Words currently stored, 0..DEPTH |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |
| prog_done | output | 1 | Offsets are loaded |

## Verification
The bench builds the block with DEPTH=128, which gives 7-bit offsets and a 14-bit serial stream. The value 64 fits in this offset width, so all three presets can be tested at their true values. At this depth the bench can also sweep every occupancy from 0 to 128 after each load. This recovers both thresholds exactly from the flag transitions, including the extreme offsets 0 and 127.

// File: rtl/apf_pkg.sv
package apf_pkg;

    typedef enum logic [1:0] {
        METH_PAR = 2'd0,
        METH_SER = 2'd1,
        METH_PRE = 2'd2
    } meth_t;

    function automatic meth_t decode_meth(input logic spm, input logic [1:0] fs);
        if (!spm)
            return METH_PAR;
        else if (fs == 2'b00)
            return METH_SER;
        else
            return METH_PRE;
    endfunction

    function automatic int preset_val(input logic [1:0] fs);
        case (fs)
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/apf_mode_latch.sv
module apf_mode_latch
    import apf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       serial_mode,
    input  logic [1:0] flag_sel,
    output meth_t      meth_now,
    output meth_t      meth,
    output logic [1:0] psel
);
    typedef struct packed {
        meth_t      meth;
        logic [1:0] psel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    assign meth_now = decode_meth(serial_mode, flag_sel);

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.meth = meth_now;
            cfg_d.psel = flag_sel;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign meth = cfg_q.meth;
    assign psel = cfg_q.psel;

    AST_METH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(meth) && $stable(psel))); // R1

endmodule

// File: rtl/apf_offset_load.sv
module apf_offset_load
    import apf_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int DW    = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  meth_t            meth_now,
    input  logic [1:0]       fs_now,
    input  meth_t            meth,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             ser_din,
    input  logic             ser_en,
    output logic [OFS_W-1:0] x_ofs,
    output logic [OFS_W-1:0] y_ofs,
    output logic             done
);
    localparam int SW   = 2 * OFS_W;
    localparam int BC_W = $clog2(SW + 1);

    typedef struct packed {
        logic [OFS_W-1:0] x;
        logic [OFS_W-1:0] y;
        logic [SW-1:0]    sh;
        logic [BC_W-1:0]  cnt;
        logic             done;
    } ld_t;

    ld_t ld_d, ld_q;
    logic [SW-1:0] sh_next;

    always_comb begin
        ld_d    = ld_q;
        sh_next = {ld_q.sh[SW-2:0], ser_din};
        if (!rst_n) begin
            if (meth_now == METH_PRE) begin
                ld_d.x = OFS_W'(preset_val(fs_now));
                ld_d.y = OFS_W'(preset_val(fs_now));
            end else begin
                ld_d.x = '0;
                ld_d.y = '0;
            end
            ld_d.sh   = '0;
            ld_d.cnt  = '0;
            ld_d.done = (meth_now == METH_PRE);
        end else if (prst_n && !ld_q.done) begin
            case (meth)
                METH_PAR: begin
                    if (wr_en) begin
                        if (ld_q.cnt == '0) begin
                            ld_d.x   = wr_data[OFS_W-1:0];
                            ld_d.cnt = BC_W'(1);
                        end else begin
                            ld_d.y    = wr_data[OFS_W-1:0];
                            ld_d.done = 1'b1;
                        end
                    end
                end
                METH_SER: begin
                    if (ser_en) begin
                        ld_d.sh  = sh_next;
                        ld_d.cnt = ld_q.cnt + BC_W'(1);
                        if (ld_q.cnt == BC_W'(SW - 1)) begin
                            ld_d.x    = sh_next[SW-1:OFS_W];
                            ld_d.y    = sh_next[OFS_W-1:0];
                            ld_d.done = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ld_q <= ld_d;
    end

    assign x_ofs = ld_q.x;
    assign y_ofs = ld_q.y;
    assign done  = ld_q.done;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(done) |-> done); // R3

    AST_OFS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(done) |-> ($stable(x_ofs) && $stable(y_ofs))); // R4

    AST_PRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(prst_n) |-> ($stable(x_ofs) && $stable(y_ofs) && $stable(done))); // R8

    AST_PRESET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && (meth == METH_PRE) |-> done); // R2

endmodule

// File: rtl/apf_flag_gen.sv
module apf_flag_gen #(
    parameter int DEPTH = 256,
    parameter int OFS_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic [CNT_W-1:0] occupancy,
    input  logic [OFS_W-1:0] x_ofs,
    input  logic [OFS_W-1:0] y_ofs,
    output logic             ae_n,
    output logic             af_n
);
    typedef struct packed {
        logic ae_n;
        logic af_n;
    } fl_t;

    fl_t fl_d, fl_q;
    logic [CNT_W-1:0] free_cnt;

    assign free_cnt = CNT_W'(DEPTH) - occupancy;

    always_comb begin
        if (!rst_n || !prst_n) begin
            fl_d.ae_n = 1'b0;
            fl_d.af_n = 1'b1;
        end else begin
            fl_d.ae_n = (occupancy > CNT_W'(x_ofs));
            fl_d.af_n = (free_cnt > CNT_W'(y_ofs));
        end
    end

    always_ff @(posedge clk) begin
        fl_q <= fl_d;
    end

    assign ae_n = fl_q.ae_n;
    assign af_n = fl_q.af_n;

    AST_PRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(prst_n) |-> (!ae_n && af_n)); // R7

    AST_EMPTY_AE: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        $past(rst_n && prst_n) && ($past(occupancy) == '0) |-> !ae_n); // R5

    AST_FULL_AF: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        $past(rst_n && prst_n) && ($past(occupancy) == CNT_W'(DEPTH)) |-> !af_n); // R6

endmodule

// File: rtl/apf_offset_prog.sv
module apf_offset_prog
    import apf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 36,
    localparam int OFS_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             serial_mode,
    input  logic [1:0]       flag_sel,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             ser_din,
    input  logic             ser_en,
    input  logic [CNT_W-1:0] occupancy,
    output logic             ae_n,
    output logic             af_n,
    output logic             prog_done
);
    meth_t            meth_now, meth;
    logic [1:0]       psel;
    logic [OFS_W-1:0] x_ofs, y_ofs;

    apf_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .serial_mode(serial_mode),
        .flag_sel   (flag_sel),
        .meth_now   (meth_now),
        .meth       (meth),
        .psel       (psel)
    );

    apf_offset_load #(.OFS_W(OFS_W), .DW(DW)) u_load (
        .clk     (clk),
        .rst_n   (rst_n),
        .prst_n  (prst_n),
        .meth_now(meth_now),
        .fs_now  (flag_sel),
        .meth    (meth),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ser_din (ser_din),
        .ser_en  (ser_en),
        .x_ofs   (x_ofs),
        .y_ofs   (y_ofs),
        .done    (prog_done)
    );

    apf_flag_gen #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .prst_n   (prst_n),
        .occupancy(occupancy),
        .x_ofs    (x_ofs),
        .y_ofs    (y_ofs),
        .ae_n     (ae_n),
        .af_n     (af_n)
    );

    AST_PRESET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && (meth == METH_PRE) |-> (x_ofs == y_ofs)); // R2

    AST_PSEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (meth == METH_PRE) |-> (psel != 2'b00)); // R1

endmodule

// File: tb/tb_apf_offset_prog.sv
module tb_apf_offset_prog;
    localparam int DEPTH = 128;
    localparam int DW    = 16;
    localparam int OW    = 7;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, prst_n = 1'b1;
    logic          serial_mode = 1'b0;
    logic [1:0]    flag_sel = 2'b00;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          ser_din = 1'b0, ser_en = 1'b0;
    logic [CW-1:0] occupancy = '0;
    logic          ae_n, af_n, prog_done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    apf_offset_prog #(.DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n),
        .serial_mode(serial_mode), .flag_sel(flag_sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .ser_din(ser_din), .ser_en(ser_en),
        .occupancy(occupancy),
        .ae_n(ae_n), .af_n(af_n), .prog_done(prog_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic full_reset(input logic spm, input logic [1:0] fs);
        @(negedge clk);
        serial_mode = spm; flag_sel = fs; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 ae_n in reset", int'(ae_n), 0);
        chk("R7 af_n in reset", int'(af_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        serial_mode = ~spm; flag_sel = ~fs;
    endtask

    task automatic sweep(input int ex, input int ey, input string tag);
        for (int o = 0; o <= DEPTH; o++) begin
            occupancy = CW'(o);
            @(negedge clk);
            chk({"R5 ", tag}, int'(ae_n), (o > ex) ? 1 : 0);
            chk({"R6 ", tag}, int'(af_n), ((DEPTH - o) > ey) ? 1 : 0);
        end
        occupancy = '0;
    endtask

    task automatic pwrite(input int v);
        wr_en = 1'b1; wr_data = DW'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sshift(input int v, input bit gap);
        for (int i = OW - 1; i >= 0; i--) begin
            ser_en = 1'b1; ser_din = v[i];
            @(negedge clk);
            if (gap && i == 3) begin
                ser_en = 1'b0; ser_din = ~v[i];
                @(negedge clk);
            end
        end
        ser_en = 1'b0;
    endtask

    task automatic par_case(input int ex, input int ey);
        full_reset(1'b0, 2'b11);
        chk("R10 par done low", int'(prog_done), 0);
        ser_en = 1'b1; ser_din = 1'b1;
        repeat (20) @(negedge clk);
        ser_en = 1'b0;
        chk("R9 sen ignored in parallel", int'(prog_done), 0);
        pwrite(ex);
        chk("R10 par done after X", int'(prog_done), 0);
        pwrite(ey);
        chk("R3 par done", int'(prog_done), 1);
        pwrite(ex ^ 7'h55);
        pwrite(ey ^ 7'h2a);
        sweep(ex, ey, "parallel");
    endtask

    task automatic ser_case(input int ex, input int ey);
        full_reset(1'b1, 2'b00);
        chk("R10 ser done low", int'(prog_done), 0);
        pwrite(5); pwrite(9); pwrite(11);
        chk("R9 wr_en ignored in serial", int'(prog_done), 0);
        sshift(ex, 1'b1);
        chk("R10 ser done after X", int'(prog_done), 0);
        sshift(ey, 1'b0);
        chk("R4 ser done", int'(prog_done), 1);
        sshift(~ex, 1'b0);
        sweep(ex, ey, "serial");
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 R2: presets
        for (int fs = 1; fs < 4; fs++) begin
            full_reset(1'b1, 2'(fs));
            chk("R2 preset done", int'(prog_done), 1);
            pwrite(3); pwrite(4);
            ser_en = 1'b1; repeat (16) @(negedge clk); ser_en = 1'b0;
            sweep(fs == 1 ? 8 : (fs == 2 ? 16 : 64), fs == 1 ? 8 : (fs == 2 ? 16 : 64), "R1 R2 R9 preset");
        end
        // R3 parallel
        par_case(5, 9);
        par_case(0, 127);
        // R8 partial reset
        @(negedge clk); prst_n = 1'b0; occupancy = CW'(64);
        repeat (3) @(negedge clk);
        chk("R7 ae_n in partial reset", int'(ae_n), 0);
        chk("R7 af_n in partial reset", int'(af_n), 1);
        pwrite(33);
        prst_n = 1'b1;
        @(negedge clk);
        chk("R8 done kept", int'(prog_done), 1);
        sweep(0, 127, "R8 after partial reset");
        // R4 serial
        ser_case(3, 100);
        ser_case(127, 0);
        // R8 partial reset in the middle of serial loading
        full_reset(1'b1, 2'b00);
        sshift(21, 1'b0);
        @(negedge clk); prst_n = 1'b0;
        ser_en = 1'b1; repeat (3) @(negedge clk); ser_en = 1'b0;
        prst_n = 1'b1; @(negedge clk);
        chk("R8 progress kept", int'(prog_done), 0);
        sshift(42, 1'b0);
        chk("R8 R4 done", int'(prog_done), 1);
        sweep(21, 42, "R8 serial resume");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule